// File: doc/BRIEF.md
# Two-Wire EEPROM Write Slave

This block is the write side of a two-wire serial memory slave sitting in front of a 1024 x 8 byte array held in registers. It watches already-synchronized clock and data lines, recognises start and stop conditions, and checks the device address byte that follows a start. When the byte selects this device for a write, it takes a word address and then one or more data bytes, acknowledging each by pulling the data line low through an open-drain enable.

Data bytes land in a 16-byte page buffer. Only the low four bits of the word address advance after each byte, so a burst stays inside one page and wraps back to its first location. A clean stop after at least one whole data byte copies the buffered bytes into the array and starts a fixed-length busy period, during which the slave ignores the bus. A write-protect input, sampled at that stop, suppresses the copy. A separate read port gives a neighbouring read engine combinational access to the array.

Top module: `eeprom_write_slave`

## Requirements
- R1: The device address byte is acknowledged only when its bits 7:4 equal 1010, bit 3 equals `strapA2` and bit 0 is 0 (write). Any other value, including a read request, is not acknowledged, and every later byte is ignored and unacknowledged until the next start.
- R2: For each accepted byte (device address, word address, data), `sdaOe` goes high after SCL falls at the end of the eighth bit and returns low after SCL falls at the end of the ninth (acknowledge) clock. `sdaOe` only changes while SCL is low.
- R3: The array location of a data byte is {device address bits 2:1, word address}, a 10-bit address.
- R4: Each data byte is written at the current word address. After it, only the low four bits of the word address increase by one, wrapping from 15 to 0 inside the same page, so a seventeenth byte overwrites the first.
- R5: A stop seen at a byte boundary after at least one complete data byte copies all received bytes into the array. `busy` is high for exactly WRITE_CYCLES clocks, starting in the clock after the stop is seen.
- R6: While `busy` is high, start, stop and data on the bus are ignored and `sdaOe` stays low.
- R7: If `wpIn` is high when the stop arrives, data bytes are still acknowledged, but the array does not change and `busy` stays low.
- R8: A start or stop arriving in the middle of a byte abandons the transfer without changing the array. A stop after only the word address starts no busy period.
- R9: After reset `sdaOe` and `busy` are low and every array byte reads 0xFF.
- R10: `rdData` shows the array byte at `rdAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized serial clock line |
| sdaIn | input | 1 | Synchronized serial data line (wired bus value) |
| strapA2 | input | 1 | Hardwired device-select strap compared with address bit 3 |
| wpIn | input | 1 | Write protect; high blocks changes to the array |
| rdAddr | input | ADDR_W | Array read address for a neighbouring read engine |
| sdaOe | output | 1 | Open-drain enable; high pulls the data line low |
| busy | output | 1 | High during the internal write cycle |
| rdData | output | 8 | Array byte at rdAddr |

## Verification
The bench targets bursts that start partway into a page and run past its end, including one longer than 16 bytes, because a design that carried into the upper address bits would scatter bytes into the next page and a design without wraparound would lose the overwrite. It sends transfers cut off by a start or stop partway through a byte and a stop right after the word address. A design that committed on any stop would corrupt the array or raise busy there. It drives a complete device address during the busy period, where a slave that still listened would acknowledge. It also checks writes under protection, where a design that gated only the acknowledge and not the commit would change the array. Address bytes with a wrong fixed pattern, a mismatched strap bit or a read bit must be refused.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_DATA,
    ST_BUSY
  } ee_state_t;

  // Strobes from the bus controller to the page datapath.
  typedef struct packed {
    logic       clear;     // new start: drop buffered bytes
    logic       loadBlk;   // device address matched: take block bits
    logic       loadWord;  // word address byte received
    logic       store;     // data byte received
    logic       commit;    // clean stop: copy page buffer into array
    logic [7:0] byteVal;   // byte just completed on the bus
  } ee_strobe_t;

endpackage

// File: rtl/ee_ctrl.sv
`timescale 1ns/1ps
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapA2,
  input  logic       wpIn,
  output ee_strobe_t strobe,
  output logic       sdaOe,
  output logic       busy
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

  ee_state_t        state;
  logic             sclQ, sdaQ;
  logic [3:0]       bitCnt;
  logic [6:0]       shReg;
  logic             ackDrive, ackOk, dataSeen;
  logic [CNT_W-1:0] busyCnt;

  logic       sclRise, sclFall, startCond, stopCond;
  logic       inFrame, byteEnd, devMatch, cleanEdge, doCommit;
  logic [7:0] rxByte;

  always_comb begin
    sclRise   = sclIn & ~sclQ;
    sclFall   = ~sclIn & sclQ;
    startCond = sclIn & sclQ & sdaQ & ~sdaIn;
    stopCond  = sclIn & sclQ & ~sdaQ & sdaIn;
    inFrame   = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_DATA);
    rxByte    = {shReg, sdaIn};
    byteEnd   = inFrame && sclRise && !ackDrive && (bitCnt == 4'd7);
    devMatch  = (rxByte[7:4] == DEV_TYPE) && (rxByte[3] == strapA2) && !rxByte[0];
    // Stop right after an ack: master's SCL rise counts at most one bit.
    cleanEdge = !ackDrive && (bitCnt <= 4'd1);
    doCommit  = stopCond && (state == ST_DATA) && cleanEdge && dataSeen && !wpIn;

    strobe          = '0;
    strobe.byteVal  = rxByte;
    strobe.clear    = startCond && (state != ST_BUSY);
    strobe.loadBlk  = byteEnd && (state == ST_DEV) && devMatch;
    strobe.loadWord = byteEnd && (state == ST_WADDR);
    strobe.store    = byteEnd && (state == ST_DATA);
    strobe.commit   = doCommit;
  end

  assign sdaOe = ackDrive;
  assign busy  = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      bitCnt   <= '0;
      shReg    <= '0;
      ackDrive <= 1'b0;
      ackOk    <= 1'b0;
      dataSeen <= 1'b0;
      busyCnt  <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (state == ST_BUSY) begin
        ackDrive <= 1'b0;
        if (busyCnt == CNT_LAST) begin
          state   <= ST_IDLE;
          busyCnt <= '0;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end else if (startCond) begin
        state    <= ST_DEV;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        ackOk    <= 1'b0;
        dataSeen <= 1'b0;
      end else if (stopCond) begin
        state    <= doCommit ? ST_BUSY : ST_IDLE;
        busyCnt  <= '0;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        dataSeen <= 1'b0;
      end else begin
        if (inFrame && sclRise && !ackDrive && (bitCnt < 4'd8)) begin
          shReg  <= rxByte[6:0];
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 4'd7) begin
            unique case (state)
              ST_DEV:   ackOk <= devMatch;
              ST_WADDR: ackOk <= 1'b1;
              ST_DATA: begin
                ackOk    <= 1'b1;
                dataSeen <= 1'b1;
              end
              default:  ackOk <= 1'b0;
            endcase
          end
        end
        if (inFrame && sclFall) begin
          if (ackDrive) begin
            ackDrive <= 1'b0;
          end else if (bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (ackOk) begin
              ackDrive <= 1'b1;
              if (state == ST_DEV)        state <= ST_WADDR;
              else if (state == ST_WADDR) state <= ST_DATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
      end
    end
  end

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn); // R2
  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn); // R2
  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R6
  AST_BUSY_NOT_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn)); // R7

endmodule

// File: rtl/ee_datapath.sv
`timescale 1ns/1ps
module ee_datapath
  import ee_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ee_strobe_t        strobe,
  input  logic              wpIn,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  localparam int WORD_W     = 8;
  localparam int BLK_W      = ADDR_W - WORD_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int DEPTH      = 1 << ADDR_W;

  logic [BLK_W-1:0]  blkBits;
  logic [WORD_W-1:0] wordAddr;
  logic [ROW_W-1:0]  pageRow;
  logic [PAGE_W-1:0] slotSel;
  logic [7:0]        pageBuf   [PAGE_BYTES];
  logic              pageValid [PAGE_BYTES];
  logic              anyValid;
  logic [7:0]        mem       [DEPTH];

  assign pageRow = {blkBits, wordAddr[WORD_W-1:PAGE_W]};
  assign slotSel = wordAddr[PAGE_W-1:0];

  always_comb begin
    anyValid = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) anyValid = anyValid | pageValid[i];
  end

  // Address register: row bits fixed per transfer, low bits wrap in page.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkBits  <= '0;
      wordAddr <= '0;
    end else if (strobe.loadBlk) begin
      blkBits <= strobe.byteVal[BLK_W:1];
    end else if (strobe.loadWord) begin
      wordAddr <= strobe.byteVal;
    end else if (strobe.store) begin
      wordAddr <= {wordAddr[WORD_W-1:PAGE_W], slotSel + PAGE_W'(1)};
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g]   <= '0;
        pageValid[g] <= 1'b0;
      end else if (strobe.clear || strobe.commit) begin
        pageValid[g] <= 1'b0;
      end else if (strobe.store && (slotSel == PAGE_W'(g))) begin
        pageBuf[g]   <= strobe.byteVal;
        pageValid[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (strobe.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageValid[i]) mem[{pageRow, PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  assign rdData = mem[rdAddr];

  AST_ROW_HELD_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |=> $stable(pageRow)); // R4
  AST_NO_COMMIT_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> !wpIn); // R7
  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> anyValid); // R5
  AST_BUSY_NO_BUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> !(strobe.store || strobe.loadWord || strobe.loadBlk || strobe.commit)); // R6

endmodule

// File: rtl/eeprom_write_slave.sv
`timescale 1ns/1ps
module eeprom_write_slave
  import ee_pkg::*;
#(
  parameter int WRITE_CYCLES = 200,
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapA2,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              sdaOe,
  output logic              busy,
  output logic [7:0]        rdData
);

  ee_strobe_t strobe;

  ee_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapA2(strapA2), .wpIn(wpIn), .strobe(strobe),
    .sdaOe(sdaOe), .busy(busy)
  );

  ee_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wpIn(wpIn),
    .busyIn(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/tb_eeprom_write_slave.sv
`timescale 1ns/1ps
module tb_eeprom_write_slave;

  localparam int WR = 400;
  localparam int Q  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapA2 = 1'b0, wpIn = 1'b0;
  logic [9:0] rdAddr = '0;
  logic sdaOe, busy;
  logic [7:0] rdData;
  logic sdaIn;
  logic ackWin = 1'b0;

  int checks = 0, errors = 0;
  int model [1024];

  always #5 clk = ~clk;
  assign sdaIn = sdaM & ~sdaOe;

  eeprom_write_slave #(.WRITE_CYCLES(WR)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn),
    .strapA2(strapA2), .wpIn(wpIn), .rdAddr(rdAddr),
    .sdaOe(sdaOe), .busy(busy), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison: acknowledge only inside the bench's window, never while busy.
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (sdaOe && (!ackWin || busy)) begin
        errors++;
        $display("FAIL R2/R6: sdaOe actual 1 expected 0 (busy=%0b)", busy);
      end
    end
  end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic doStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic stopRise();  // ends with SDA rising at a negedge
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input bit openWin);
    for (int i = 0; i < n; i++) begin
      sdaM = b[7-i]; q(); sclM = 1'b1; q(); q(); sclM = 1'b0;
      if (openWin && i == n - 1) ackWin = 1'b1;
      q();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    sendBits(b, 8, 1'b1);
    sdaM = 1'b1; q(); sclM = 1'b1; q();
    chk((sdaIn == 1'b0) == expAck, tag, int'(sdaIn == 1'b0), int'(expAck));
    q(); sclM = 1'b0; q();
    ackWin = 1'b0;
  endtask

  task automatic checkMem(input string tag);
    int bad = -1;
    for (int a = 0; a < 1024; a++) begin
      rdAddr = 10'(a);
      #1;
      if (bad < 0 && rdData !== 8'(model[a])) bad = a;
    end
    if (bad >= 0) begin
      rdAddr = 10'(bad); #1;
      chk(1'b0, $sformatf("%s mem[%0h]", tag, bad), int'(rdData), model[bad]);
    end else begin
      chk(1'b1, tag, 0, 0);
    end
  endtask

  task automatic txn(input logic [7:0] dev, input logic [7:0] wa, input int n,
                     input int base, input bit waitDone, input string tag);
    bit devAck, commit;
    logic [7:0] lo;
    devAck = (dev[7:4] == 4'hA) && (dev[3] == strapA2) && !dev[0];
    commit = devAck && (n > 0) && !wpIn;
    doStart();
    sendByte(dev, devAck, {tag, " R1 dev ack"});
    sendByte(wa, devAck, {tag, " R2 word ack"});
    for (int i = 0; i < n; i++) sendByte(8'(base + i * 7), devAck, {tag, " R2 data ack"});
    stopRise();
    if (commit) begin
      for (int i = 0; i < n; i++) begin
        lo = 8'(wa[3:0] + i) & 8'h0F;
        model[{dev[2:1], wa[7:4], lo[3:0]}] = base + i * 7;  // R3 R4
      end
    end
    @(negedge clk);
    chk(busy == commit, {tag, " R5 busy after stop"}, int'(busy), int'(commit));
    if (waitDone) begin
      if (commit) begin
        repeat (WR - 1) @(negedge clk);
        chk(busy == 1'b1, {tag, " R5 busy last cycle"}, int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, {tag, " R5 busy ends"}, int'(busy), 0);
      end else begin
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, {tag, " R8 no busy"}, int'(busy), 0);
      end
      checkMem({tag, " R10 array"});
    end
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) model[a] = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sdaOe == 1'b0, "R9 reset sdaOe", int'(sdaOe), 0);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    checkMem("R9 reset array");

    // Byte write, block 1
    txn(8'hA2, 8'h12, 1, 8'h5A, 1'b1, "R3 byte write");
    // Page write from mid-page, wraps inside page (block 2)
    txn(8'hA4, 8'h3C, 16, 8'h01, 1'b1, "R4 page wrap");
    // 18 bytes: last two overwrite the first two (block 3)
    txn(8'hA6, 8'hF0, 18, 8'h20, 1'b1, "R4 overwrite");
    // Wrong fixed pattern
    txn(8'hB0, 8'h00, 2, 8'h77, 1'b1, "R1 bad type");
    // Strap mismatch, then match
    strapA2 = 1'b1;
    txn(8'hA0, 8'h40, 1, 8'h33, 1'b1, "R1 strap mismatch");
    txn(8'hA8, 8'h41, 1, 8'h44, 1'b1, "R1 strap match");
    // Read request refused
    txn(8'hA9, 8'h42, 1, 8'h55, 1'b1, "R1 read bit");
    strapA2 = 1'b0;
    // Write protect
    wpIn = 1'b1;
    txn(8'hA0, 8'h80, 3, 8'h66, 1'b1, "R7 protected");
    wpIn = 1'b0;
    // Stop after word address only
    txn(8'hA0, 8'h90, 0, 8'h00, 1'b1, "R8 no data");

    // Start in mid-byte aborts
    doStart();
    sendByte(8'hA0, 1'b1, "R8 abort dev");
    sendByte(8'h50, 1'b1, "R8 abort word");
    sendByte(8'h99, 1'b1, "R8 abort data");
    sendBits(8'hC3, 4, 1'b0);
    doStart();
    stopRise();
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R8 start mid-byte busy", int'(busy), 0);
    checkMem("R8 start mid-byte array");

    // Stop in mid-byte aborts
    doStart();
    sendByte(8'hA0, 1'b1, "R8 abort2 dev");
    sendByte(8'h60, 1'b1, "R8 abort2 word");
    sendByte(8'h88, 1'b1, "R8 abort2 data");
    sendBits(8'hE0, 3, 1'b0);
    stopRise();
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R8 stop mid-byte busy", int'(busy), 0);
    checkMem("R8 stop mid-byte array");

    // Bus ignored during busy
    txn(8'hA0, 8'h07, 1, 8'hC4, 1'b0, "R6 pre-busy");
    sclM = 1'b0; q();
    doStart();
    sendByte(8'hA0, 1'b0, "R6 dev during busy");
    chk(busy == 1'b1, "R6 still busy", int'(busy), 1);
    sclM = 1'b1;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    checkMem("R6 array after busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule